// File: doc/BRIEF.md
# Enable-Aligned Pixel Clock Divider

This block divides a fast input clock by one of several selectable moduli and delivers a pixel clock with an exact 50% duty cycle, odd moduli included. It runs in half input-clock steps. Each posedge register decides the level for the first half of the coming input period. A falling-edge register decides the level for the second half. The XOR of the two registers forms the output.

Output cycles run only while an external enable is active. The enable is typically a conditioned beam-detect pulse, and its active level is programmable. When the enable becomes active, the divider restarts. The output stays high for a fixed number of half input periods that depends on the select code, and then its first cycle begins with a falling edge. So the pixel clock phase is tied to the input clock edge that saw the enable. When the enable goes inactive, the cycle in progress runs to the end of its high phase and the output then parks high.

A static disable input blocks the divider in the same way as an inactive enable. A static test select can hand the output to a single level bit for board test. All configuration inputs are static levels sampled on the input clock.

Top module: `pixclk_sync_div`

## Requirements
- R1: The modulus select maps these codes to an output period of N input periods: 0→3, 1→4, 2→4, 3→5, 4→6, 5→8, 6→8, 7→10, 8→12, 9→16, 10→16, 11→20. When bit 3 is set, bit 2 is ignored, so codes 12 to 15 behave like codes 8 to 11.
- R2: While running, every output cycle is N half input periods low followed by N half input periods high. This gives exactly 50% duty, including for N = 3 and N = 5.
- R3: The enable is sampled at an input clock rising edge. At the first such edge where it is seen active after being seen inactive, the output is held high for L half input periods and then falls, which starts the first cycle. L is, for codes 0 to 11: 4, 7, 6, 9, 7, 11, 10, 14, 13, 19, 18, 24.
- R4: The enable counts as active when its level equals the polarity input: a polarity of 0 means active low, and 1 means active high.
- R5: When the enable is seen inactive, the cycle in progress finishes its high phase and the output then stays high. If the enable goes inactive before the first falling edge, the output simply stays high. While idle, the output is high.
- R6: While the disable input is 1, the enable is treated as inactive. A running divider completes its cycle and parks high, and no new start can occur. Clearing the disable while the enable is active counts as a new assertion.
- R7: While the test select equals 2'b11, both halves of each input period carry the auxiliary level sampled at that period's rising edge. The divider keeps its timing in the background.
- R8: The modulus select is captured only at a start. Changing it while running has no effect until the next assertion.
- R9: During synchronous reset the output is high and the divider is idle. An enable that is already active when reset is released counts as an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Alignment enable pulse |
| en_pol_i | input | 1 | Active level of en_i |
| dis_i | input | 1 | Forced divider disable |
| sel_i | input | 4 | Modulus select code |
| tst_i | input | 2 | Test select; 2'b11 gives the output to aux_i |
| aux_i | input | 1 | Output level in test mode |
| pclk_o | output | 1 | Pixel clock output |

## Verification
A wrong half-step counter or a wrong latency shows at the port within one output period. It appears as a low or high phase one half input period too long or too short, or as a first falling edge in the wrong half. The bench samples both halves of every input period, so any such error shows in the first half period where it occurs. A select captured at the wrong time, or a stop request that is lost, only shows at the next period boundary or after the deassertion. The stimulus therefore changes the select in mid-run and deasserts the enable both in the latency window and in the middle of cycles.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  localparam int SEL_W  = 4;
  localparam int TST_W  = 2;
  localparam int MOD_W  = 5;
  localparam int PH_W   = MOD_W + 1;
  localparam int WAIT_W = 5;
  localparam logic [TST_W-1:0] TST_AUX = 2'b11;

  typedef struct packed {
    logic              run;
    logic              stop;
    logic [WAIT_W-1:0] wcnt;
    logic [PH_W-1:0]   ph;
  } seq_st_t;

  typedef struct packed {
    logic    lvl;
    seq_st_t st;
  } half_res_t;

  // codes with bit 3 set ignore bit 2
  function automatic logic [SEL_W-1:0] sel_norm(logic [SEL_W-1:0] s);
    return s[3] ? {2'b10, s[1:0]} : s;
  endfunction

  function automatic logic [MOD_W-1:0] mod_of(logic [SEL_W-1:0] s);
    case (sel_norm(s))
      4'd0:    return MOD_W'(3);
      4'd1:    return MOD_W'(4);
      4'd2:    return MOD_W'(4);
      4'd3:    return MOD_W'(5);
      4'd4:    return MOD_W'(6);
      4'd5:    return MOD_W'(8);
      4'd6:    return MOD_W'(8);
      4'd7:    return MOD_W'(10);
      4'd8:    return MOD_W'(12);
      4'd9:    return MOD_W'(16);
      4'd10:   return MOD_W'(16);
      default: return MOD_W'(20);
    endcase
  endfunction

  // start latency in half input periods
  function automatic logic [WAIT_W-1:0] lat_of(logic [SEL_W-1:0] s);
    case (sel_norm(s))
      4'd0:    return WAIT_W'(4);
      4'd1:    return WAIT_W'(7);
      4'd2:    return WAIT_W'(6);
      4'd3:    return WAIT_W'(9);
      4'd4:    return WAIT_W'(7);
      4'd5:    return WAIT_W'(11);
      4'd6:    return WAIT_W'(10);
      4'd7:    return WAIT_W'(14);
      4'd8:    return WAIT_W'(13);
      4'd9:    return WAIT_W'(19);
      4'd10:   return WAIT_W'(18);
      default: return WAIT_W'(24);
    endcase
  endfunction

  // advance the sequencer by one half input period
  function automatic half_res_t half_step(seq_st_t s, logic [MOD_W-1:0] m);
    half_res_t       r;
    logic [PH_W-1:0] last;
    last  = (PH_W'(m) << 1) - PH_W'(1);
    r.st  = s;
    r.lvl = 1'b1;
    if (s.run) begin
      if (s.wcnt != '0) begin
        if (s.stop) r.st.run = 1'b0;
        else        r.st.wcnt = s.wcnt - WAIT_W'(1);
      end else begin
        r.lvl = (s.ph >= PH_W'(m));
        if (s.ph == last) begin
          r.st.ph = '0;
          if (s.stop) r.st.run = 1'b0;
        end else begin
          r.st.ph = s.ph + PH_W'(1);
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pxd_en_ctl.sv
module pxd_en_ctl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic en_pol_i,
  input  logic dis_i,
  output logic act_o,
  output logic start_o
);
  logic act_q;

  assign act_o   = (en_i == en_pol_i) && !dis_i;
  assign start_o = act_o && !act_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) act_q <= 1'b0;
    else       act_q <= act_o;
  end
endmodule

// File: rtl/pxd_seq.sv
module pxd_seq
  import pxd_pkg::*;
#(
  parameter logic [SEL_W-1:0] RST_SEL = 4'd1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             act_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TST_W-1:0] tst_i,
  input  logic             aux_i,
  output logic             first_o,
  output logic             second_o,
  output logic             run_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [PH_W-1:0]  ph_o
);
  seq_st_t          st_q, st_in;
  logic [MOD_W-1:0] mod_q, mod_use;
  half_res_t        hr0, hr1;

  always_comb begin
    st_in   = st_q;
    mod_use = mod_q;
    if (start_i) begin
      st_in.run  = 1'b1;
      st_in.stop = 1'b0;
      st_in.wcnt = lat_of(sel_i);
      st_in.ph   = '0;
      mod_use    = mod_of(sel_i);
    end else if (!act_i && st_q.run) begin
      st_in.stop = 1'b1;
    end
  end

  assign hr0 = half_step(st_in, mod_use);
  assign hr1 = half_step(hr0.st, mod_use);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= '0;
      mod_q <= mod_of(RST_SEL);
    end else begin
      st_q  <= hr1.st;
      mod_q <= mod_use;
    end
  end

  assign first_o  = (tst_i == TST_AUX) ? aux_i : hr0.lvl;
  assign second_o = (tst_i == TST_AUX) ? aux_i : hr1.lvl;
  assign run_o    = st_q.run;
  assign mod_o    = mod_q;
  assign ph_o     = st_q.ph;
endmodule

// File: rtl/pxd_halfmux.sv
module pxd_halfmux (
  input  logic clk_i,
  input  logic rst_i,
  input  logic first_i,
  input  logic second_i,
  output logic pclk_o
);
  logic p_q, s_q, n_q;

  // p_q ^ n_q gives first_i after the rising edge, second_i after the falling edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      p_q <= 1'b1;
      s_q <= 1'b1;
    end else begin
      p_q <= first_i ^ n_q;
      s_q <= second_i;
    end
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) n_q <= 1'b0;
    else       n_q <= s_q ^ p_q;
  end

  assign pclk_o = p_q ^ n_q;
endmodule

// File: rtl/pixclk_sync_div.sv
module pixclk_sync_div
  import pxd_pkg::*;
#(
  parameter logic [SEL_W-1:0] RST_SEL = 4'd1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             en_pol_i,
  input  logic             dis_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TST_W-1:0] tst_i,
  input  logic             aux_i,
  output logic             pclk_o
);
  logic             act, start, lvl_a, lvl_b, seq_run;
  logic [MOD_W-1:0] seq_mod;
  logic [PH_W-1:0]  seq_ph;

  pxd_en_ctl u_en (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .en_pol_i(en_pol_i),
    .dis_i(dis_i), .act_o(act), .start_o(start)
  );

  pxd_seq #(.RST_SEL(RST_SEL)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start), .act_i(act),
    .sel_i(sel_i), .tst_i(tst_i), .aux_i(aux_i),
    .first_o(lvl_a), .second_o(lvl_b), .run_o(seq_run),
    .mod_o(seq_mod), .ph_o(seq_ph)
  );

  pxd_halfmux u_out (
    .clk_i(clk_i), .rst_i(rst_i), .first_i(lvl_a), .second_i(lvl_b),
    .pclk_o(pclk_o)
  );
endmodule

// File: rtl/pixclk_sync_div_chk.sv
module pixclk_sync_div_chk
  import pxd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             en_pol_i,
  input logic             dis_i,
  input logic [TST_W-1:0] tst_i,
  input logic             aux_i,
  input logic             pclk_o,
  input logic             start,
  input logic             seq_run,
  input logic [MOD_W-1:0] seq_mod,
  input logic [PH_W-1:0]  seq_ph
);
  AST_AUX_DRIVES_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
    tst_i == TST_AUX |=> pclk_o == $past(aux_i)); // R7
  AST_IDLE_PARKS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (!seq_run && !start && tst_i != TST_AUX) |=> pclk_o); // R5
  AST_START_HELD_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (start && tst_i != TST_AUX) |=> pclk_o); // R3
  AST_PHASE_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_run |-> seq_ph < {seq_mod, 1'b0}); // R2
  AST_MOD_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    !start |=> $stable(seq_mod)); // R8
  AST_DISABLE_BLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
    dis_i |-> !start); // R6
  AST_POLARITY_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    start |-> en_i == en_pol_i); // R4
endmodule

bind pixclk_sync_div pixclk_sync_div_chk chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .en_pol_i(en_pol_i),
  .dis_i(dis_i), .tst_i(tst_i), .aux_i(aux_i), .pclk_o(pclk_o),
  .start(start), .seq_run(seq_run), .seq_mod(seq_mod), .seq_ph(seq_ph)
);

// File: tb/pixclk_sync_div_tb_top.sv
`timescale 1ns/1ps
module pixclk_sync_div_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1, pol = 1'b0, dis = 1'b0, aux = 1'b0;
  logic [3:0] sel = 4'd0;
  logic [1:0] tst = 2'd0;
  logic       pclk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R9";

  always #10 clk = ~clk;

  pixclk_sync_div dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .en_pol_i(pol), .dis_i(dis),
    .sel_i(sel), .tst_i(tst), .aux_i(aux), .pclk_o(pclk)
  );

  // reference model, in half input periods
  int  m_run = 0, m_stop = 0, m_wait = 0, m_ph = 0, m_n = 4, m_prev = 0, m_rst_seen = 0;
  bit  exp_a = 1'b1, exp_b = 1'b1, armed = 1'b0;

  function automatic int ref_n(logic [3:0] c);
    casez (c)
      4'b0000: return 3;  4'b0001: return 4;  4'b0010: return 4;  4'b0011: return 5;
      4'b0100: return 6;  4'b0101: return 8;  4'b0110: return 8;  4'b0111: return 10;
      4'b1?00: return 12; 4'b1?01: return 16; 4'b1?10: return 16; default: return 20;
    endcase
  endfunction

  function automatic int ref_lat(logic [3:0] c);
    casez (c)
      4'b0000: return 4;  4'b0001: return 7;  4'b0010: return 6;  4'b0011: return 9;
      4'b0100: return 7;  4'b0101: return 11; 4'b0110: return 10; 4'b0111: return 14;
      4'b1?00: return 13; 4'b1?01: return 19; 4'b1?10: return 18; default: return 24;
    endcase
  endfunction

  task automatic m_half(output bit lvl);
    lvl = 1'b1;
    if (m_run != 0) begin
      if (m_wait > 0) begin
        if (m_stop != 0) m_run = 0;
        else m_wait--;
      end else begin
        lvl = (m_ph >= m_n);
        m_ph++;
        if (m_ph == 2 * m_n) begin
          m_ph = 0;
          if (m_stop != 0) m_run = 0;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    bit a, b;
    int act;
    if (rst) begin
      m_run = 0; m_stop = 0; m_prev = 0; m_n = 4;
      exp_a = 1'b1; exp_b = 1'b1;
      m_rst_seen++;
      if (m_rst_seen >= 2) armed = 1'b1;
    end else begin
      act = (en == pol) && !dis;
      if (act != 0 && m_prev == 0) begin
        m_run = 1; m_stop = 0; m_ph = 0;
        m_wait = ref_lat(sel); m_n = ref_n(sel);
      end else if (act == 0 && m_run != 0) begin
        m_stop = 1;
      end
      m_prev = act;
      m_half(a);
      m_half(b);
      if (tst == 2'b11) begin a = aux; b = aux; end
      exp_a = a; exp_b = b;
    end
  end

  task automatic cmp(bit exp, string half);
    n_cmp++;
    if (pclk !== exp) begin
      n_bad++;
      $display("FAIL %s %s half at %0t: pclk=%b expected %b", cur_req, half, $time, pclk, exp);
    end
  endtask

  always @(posedge clk) begin
    bit ea, eb;
    #5;
    ea = exp_a; eb = exp_b;
    if (armed) cmp(ea, "first");
    #10;
    if (armed) cmp(eb, "second");
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(bit active);
    en = active ? pol : ~pol;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: reset holds output high
    cur_req = "R9";
    wait_cyc(5);
    rst = 1'b0;
    cur_req = "R5 idle";
    wait_cyc(10);

    // R1 R2 R3 R4: every code, polarity alternating
    for (int c = 0; c < 16; c++) begin
      cur_req = "R1 R2 R3 R4";
      @(negedge clk);
      pol = c[0];
      sel = 4'(c);
      set_en(1'b0);
      wait_cyc(25);
      set_en(1'b1);
      wait_cyc(3 * ref_n(4'(c)) + 15);
      cur_req = "R5 stop";
      set_en(1'b0);
      wait_cyc(30);
    end

    // R8: select change while running
    cur_req = "R8";
    sel = 4'd0;
    set_en(1'b1);
    wait_cyc(10);
    sel = 4'd11;
    wait_cyc(25);
    set_en(1'b0);
    wait_cyc(25);
    set_en(1'b1);
    wait_cyc(50);
    set_en(1'b0);
    wait_cyc(25);

    // R5: deassert inside the start latency
    cur_req = "R5 early";
    set_en(1'b1);
    wait_cyc(3);
    set_en(1'b0);
    wait_cyc(30);

    // R6: forced disable
    cur_req = "R6";
    sel = 4'd3;
    dis = 1'b1;
    set_en(1'b1);
    wait_cyc(20);
    dis = 1'b0;
    wait_cyc(20);
    dis = 1'b1;
    wait_cyc(20);
    set_en(1'b0);
    dis = 1'b0;
    wait_cyc(10);

    // R7: test mode over a running divider
    cur_req = "R7";
    sel = 4'd4;
    set_en(1'b1);
    wait_cyc(8);
    tst = 2'b11;
    for (int k = 0; k < 12; k++) begin
      aux = k[0] ^ k[2];
      wait_cyc(1);
    end
    tst = 2'b10;
    aux = 1'b1;
    wait_cyc(20);
    tst = 2'b00;
    wait_cyc(20);
    set_en(1'b0);
    wait_cyc(20);

    // R9: enable already active at reset release
    cur_req = "R9 restart";
    rst = 1'b1;
    sel = 4'd7;
    set_en(1'b1);
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(40);
    set_en(1'b0);
    wait_cyc(25);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule